// File: doc/BRIEF.md
# Atomic memory operation unit

This unit carries out word-sized atomic read-modify-write instructions for a small in-order core. The core hands it one decoded instruction at a time: the major opcode, funct3, funct7, the destination register index and the values of the two source registers. The first source value is the memory address. For the arithmetic, logical, swap and min/max forms, the unit reads the addressed word and writes back the combination of that word with the second source value. It then returns the word as it was before the update for the destination register.

The unit also keeps a single reservation for the load-reserved / store-conditional pair. A load-reserved returns the word and remembers its word address. A later store-conditional to the same word address stores the second source value and returns zero. In every other case the store-conditional stores nothing and returns one. Either way the reservation is consumed. Memory traffic goes through a plain request/acknowledge port that uses a combinational read-data return. Results leave through a register write-back strobe.

The core presents a request only while `busy` is low. Encodings that are not legal raise `illegalInstr` for one cycle. Addresses that are not on a word boundary raise `misalignedFault` for one cycle. Neither of these touches memory.

Top module: `amoUnit`

## Requirements
- R1: A request is taken only when `reqOpcode` is 7'h2F. With any other opcode the unit issues no memory access, produces no write-back and raises no fault.
- R2: With opcode 7'h2F and `reqFunct3` other than 3'h2, `illegalInstr` is high for the one cycle after the request edge, and no memory access or write-back follows.
- R3: The operation is chosen by funct5 = `reqFunct7[6:2]`. The codes are 5'h00 add, 5'h01 swap, 5'h02 load-reserved, 5'h03 store-conditional, 5'h04 xor, 5'h08 or, 5'h0C and, 5'h10 signed min, 5'h14 signed max, 5'h18 unsigned min and 5'h1C unsigned max. Any other funct5 behaves as in R2.
- R4: `reqFunct7[1:0]` has no effect on which operation runs or on its result.
- R5: Each read-modify-write issues exactly one read and then exactly one write to the same address. The write carries old OP rs2, and swap writes rs2 alone. The write-back data is the old word.
- R6: Signed min/max compare the two words as two's-complement values. Unsigned min/max compare them as unsigned values.
- R7: Load-reserved performs one read, writes the word back to rd, performs no memory write, and records a reservation on address bits [31:2].
- R8: Store-conditional with a valid reservation whose bits [31:2] equal those of the address writes rs2 once and returns 0. In every other case it accesses no memory and returns 1. In both cases the reservation is cleared.
- R9: A legal encoding whose address has bits [1:0] not equal to zero raises `misalignedFault` for the one cycle after the request edge. No memory access follows and the reservation is left unchanged.
- R10: When rd is 0, `wbValid` stays low, and the memory side effects still take place.
- R11: `busy` is high from the cycle after an accepted request until the cycle after its write-back. `memReq` is high only while `busy` is high. An unacknowledged request holds its address and direction. No request follows the write of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Instruction presented this cycle |
| reqOpcode | input | 7 | Major opcode |
| reqFunct3 | input | 3 | Width field |
| reqFunct7 | input | 7 | Operation code and two ordering bits |
| reqRd | input | 5 | Destination register index |
| rs1Val | input | 32 | Address operand |
| rs2Val | input | 32 | Data operand |
| busy | output | 1 | Sequence in progress; no new request is taken |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Word address of the request |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request completes this cycle |
| memRdata | input | 32 | Read data, valid with memAck |
| wbValid | output | 1 | Register write-back strobe |
| wbRd | output | 5 | Write-back register index |
| wbData | output | 32 | Write-back value |
| illegalInstr | output | 1 | Illegal encoding pulse |
| misalignedFault | output | 1 | Misaligned address pulse |

## Verification
The bound checker watches the memory handshake on every cycle. It checks that requests appear only while busy, that a stalled request keeps its address and direction, that addresses are word aligned, that nothing is requested after the write of a sequence, and that a write-back never names x0. It also checks that a write-back, an illegal pulse and a misaligned pulse never coincide. The bench scenarios are the only way to show the data results, because they depend on the operation that was requested. These results are the combined words for every funct5, the signed and unsigned orderings, the ignored ordering bits, the store-conditional success and failure codes after matching, mismatching and missing reservations, and the access counts under memory stalls.

// File: rtl/amoPkg.sv
package amoPkg;

  localparam logic [6:0] AMO_OPCODE  = 7'h2F;
  localparam logic [2:0] WORD_FUNCT3 = 3'h2;

  typedef enum logic [4:0] {
    OP_ADD  = 5'h00,
    OP_SWAP = 5'h01,
    OP_LR   = 5'h02,
    OP_SC   = 5'h03,
    OP_XOR  = 5'h04,
    OP_OR   = 5'h08,
    OP_AND  = 5'h0C,
    OP_MIN  = 5'h10,
    OP_MAX  = 5'h14,
    OP_MINU = 5'h18,
    OP_MAXU = 5'h1C
  } amoOp_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RESP
  } amoState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadOps;    // latch address and data operand
    logic captureOld; // latch read data
    logic scPass;     // store-conditional outcome: success
    logic scFail;     // store-conditional outcome: failure
    logic setResv;    // record reservation on latched address
    logic clearResv;  // drop reservation
  } amoStrobe_t;

endpackage

// File: rtl/amoCtrl.sv
module amoCtrl
  import amoPkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [6:0]           reqOpcode,
  input  logic [2:0]           reqFunct3,
  input  logic [6:0]           reqFunct7,
  input  logic [REG_IDX_W-1:0] reqRd,
  input  logic                 addrMisaligned,
  input  logic                 resvHit,
  input  logic                 memAck,
  output logic                 busy,
  output logic                 memReq,
  output logic                 memWe,
  output amoOp_e               opQ,
  output amoStrobe_t           strobe,
  output logic                 wbValid,
  output logic [REG_IDX_W-1:0] wbRd,
  output logic                 illegalInstr,
  output logic                 misalignedFault
);

  amoState_e stateQ, stateD;
  logic [REG_IDX_W-1:0] rdQ;
  logic [4:0] funct5;
  logic legalF5, accept, badInstr, badAddr, start, isSc;
  logic unusedOrderBits;

  assign funct5          = reqFunct7[6:2];
  assign unusedOrderBits = ^reqFunct7[1:0];

  always_comb begin
    case (funct5)
      OP_ADD, OP_SWAP, OP_LR, OP_SC, OP_XOR, OP_OR, OP_AND,
      OP_MIN, OP_MAX, OP_MINU, OP_MAXU: legalF5 = 1'b1;
      default:                          legalF5 = 1'b0;
    endcase
  end

  assign accept   = (stateQ == ST_IDLE) && reqValid && (reqOpcode == AMO_OPCODE);
  assign badInstr = accept && ((reqFunct3 != WORD_FUNCT3) || !legalF5);
  assign badAddr  = accept && !badInstr && addrMisaligned;
  assign start    = accept && !badInstr && !badAddr;
  assign isSc     = (funct5 == OP_SC);

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        strobe.loadOps = start;
        if (start) begin
          if (isSc) begin
            strobe.scPass    = resvHit;
            strobe.scFail    = !resvHit;
            strobe.clearResv = 1'b1;
            stateD           = resvHit ? ST_WRITE : ST_RESP;
          end else begin
            stateD = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (memAck) begin
          strobe.captureOld = 1'b1;
          strobe.setResv    = (opQ == OP_LR);
          stateD            = (opQ == OP_LR) ? ST_RESP : ST_WRITE;
        end
      end
      ST_WRITE: if (memAck) stateD = ST_RESP;
      ST_RESP:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ          <= ST_IDLE;
      opQ             <= OP_ADD;
      rdQ             <= '0;
      illegalInstr    <= 1'b0;
      misalignedFault <= 1'b0;
    end else begin
      stateQ          <= stateD;
      illegalInstr    <= badInstr;
      misalignedFault <= badAddr;
      if (start) begin
        opQ <= amoOp_e'(funct5);
        rdQ <= reqRd;
      end
    end
  end

  assign busy    = (stateQ != ST_IDLE);
  assign memReq  = (stateQ == ST_READ) || (stateQ == ST_WRITE);
  assign memWe   = (stateQ == ST_WRITE);
  assign wbValid = (stateQ == ST_RESP) && (rdQ != '0);
  assign wbRd    = rdQ;

endmodule

// File: rtl/amoDatapath.sv
module amoDatapath
  import amoPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rs1Val,
  input  logic [DATA_W-1:0] rs2Val,
  input  logic [DATA_W-1:0] memRdata,
  input  amoOp_e            opQ,
  input  amoStrobe_t        strobe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] wbData,
  output logic              addrMisaligned,
  output logic              resvHit
);

  localparam int BYTE_OFF = $clog2(DATA_W / 8);
  localparam int WORD_W   = ADDR_W - BYTE_OFF;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] rs2Q, oldQ;
  logic              scFailQ;
  logic              resvValidQ;
  logic [WORD_W-1:0] resvWordQ;
  logic              signedLess, unsignedLess;

  assign addrMisaligned = |rs1Val[BYTE_OFF-1:0];
  assign resvHit        = resvValidQ && (resvWordQ == rs1Val[ADDR_W-1:BYTE_OFF]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ      <= '0;
      rs2Q       <= '0;
      oldQ       <= '0;
      scFailQ    <= 1'b0;
      resvValidQ <= 1'b0;
      resvWordQ  <= '0;
    end else begin
      if (strobe.loadOps) begin
        addrQ <= rs1Val;
        rs2Q  <= rs2Val;
      end
      if (strobe.captureOld) oldQ    <= memRdata;
      if (strobe.scPass)     scFailQ <= 1'b0;
      if (strobe.scFail)     scFailQ <= 1'b1;
      if (strobe.clearResv)  resvValidQ <= 1'b0;
      else if (strobe.setResv) begin
        resvValidQ <= 1'b1;
        resvWordQ  <= addrQ[ADDR_W-1:BYTE_OFF];
      end
    end
  end

  assign signedLess   = $signed(oldQ) < $signed(rs2Q);
  assign unsignedLess = oldQ < rs2Q;

  always_comb begin
    case (opQ)
      OP_ADD:  memWdata = oldQ + rs2Q;
      OP_XOR:  memWdata = oldQ ^ rs2Q;
      OP_OR:   memWdata = oldQ | rs2Q;
      OP_AND:  memWdata = oldQ & rs2Q;
      OP_MIN:  memWdata = signedLess ? oldQ : rs2Q;
      OP_MAX:  memWdata = signedLess ? rs2Q : oldQ;
      OP_MINU: memWdata = unsignedLess ? oldQ : rs2Q;
      OP_MAXU: memWdata = unsignedLess ? rs2Q : oldQ;
      default: memWdata = rs2Q; // swap and store-conditional
    endcase
  end

  assign memAddr = addrQ;
  assign wbData  = (opQ == OP_SC) ? {{(DATA_W-1){1'b0}}, scFailQ} : oldQ;

endmodule

// File: rtl/amoUnit.sv
module amoUnit
  import amoPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [6:0]           reqOpcode,
  input  logic [2:0]           reqFunct3,
  input  logic [6:0]           reqFunct7,
  input  logic [REG_IDX_W-1:0] reqRd,
  input  logic [ADDR_W-1:0]    rs1Val,
  input  logic [DATA_W-1:0]    rs2Val,
  output logic                 busy,
  output logic                 memReq,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  input  logic                 memAck,
  input  logic [DATA_W-1:0]    memRdata,
  output logic                 wbValid,
  output logic [REG_IDX_W-1:0] wbRd,
  output logic [DATA_W-1:0]    wbData,
  output logic                 illegalInstr,
  output logic                 misalignedFault
);

  amoOp_e     opQ;
  amoStrobe_t strobe;
  logic       addrMisaligned, resvHit;

  amoCtrl #(.REG_IDX_W(REG_IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOpcode(reqOpcode),
    .reqFunct3(reqFunct3), .reqFunct7(reqFunct7), .reqRd(reqRd),
    .addrMisaligned(addrMisaligned), .resvHit(resvHit), .memAck(memAck),
    .busy(busy), .memReq(memReq), .memWe(memWe), .opQ(opQ), .strobe(strobe),
    .wbValid(wbValid), .wbRd(wbRd), .illegalInstr(illegalInstr),
    .misalignedFault(misalignedFault)
  );

  amoDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .rs1Val(rs1Val), .rs2Val(rs2Val),
    .memRdata(memRdata), .opQ(opQ), .strobe(strobe), .memAddr(memAddr),
    .memWdata(memWdata), .wbData(wbData), .addrMisaligned(addrMisaligned),
    .resvHit(resvHit)
  );

endmodule

// File: rtl/amoChecker.sv
module amoChecker #(
  parameter int ADDR_W    = 32,
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busy,
  input logic                 memReq,
  input logic                 memWe,
  input logic [ADDR_W-1:0]    memAddr,
  input logic                 memAck,
  input logic                 wbValid,
  input logic [REG_IDX_W-1:0] wbRd,
  input logic                 illegalInstr,
  input logic                 misalignedFault
);

  assert_req_in_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  assert_write_ends_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck) |=> !memReq);

  assert_aligned_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));

  assert_fault_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (misalignedFault || illegalInstr) |-> !busy);

  assert_no_x0_wb_R10: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (wbRd != '0));

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wbValid, illegalInstr, misalignedFault}));

  assert_wb_then_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !busy);

endmodule

bind amoUnit amoChecker #(.ADDR_W(ADDR_W), .REG_IDX_W(REG_IDX_W)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memAck(memAck), .wbValid(wbValid), .wbRd(wbRd),
  .illegalInstr(illegalInstr), .misalignedFault(misalignedFault)
);

// File: tb/amoUnit_tb_top.sv
`timescale 1ns/1ps
module amoUnit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [6:0]  reqOpcode = '0;
  logic [2:0]  reqFunct3 = '0;
  logic [6:0]  reqFunct7 = '0;
  logic [4:0]  reqRd = '0;
  logic [31:0] rs1Val = '0, rs2Val = '0;
  logic        busy, memReq, memWe, memAck, wbValid;
  logic [31:0] memAddr, memWdata, memRdata, wbData;
  logic [4:0]  wbRd;
  logic        illegalInstr, misalignedFault;
  logic        ackEn = 1'b1;
  bit          stallMode = 1'b0;

  logic [31:0] mem    [16];
  logic [31:0] refMem [16];
  int          accessCount = 0, writeCount = 0;
  int          checks = 0, failures = 0;
  bit          finished = 1'b0;
  bit          resV = 1'b0;
  logic [29:0] resA = '0;

  always #10 clk = ~clk;

  amoUnit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOpcode(reqOpcode),
    .reqFunct3(reqFunct3), .reqFunct7(reqFunct7), .reqRd(reqRd),
    .rs1Val(rs1Val), .rs2Val(rs2Val), .busy(busy), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .wbValid(wbValid), .wbRd(wbRd), .wbData(wbData),
    .illegalInstr(illegalInstr), .misalignedFault(misalignedFault)
  );

  // Memory model: combinational read, write on the acknowledged edge
  assign memAck   = memReq && ackEn;
  assign memRdata = mem[memAddr[5:2]];

  always @(posedge clk) begin
    if (memReq && memAck) begin
      accessCount <= accessCount + 1;
      if (memWe) begin
        mem[memAddr[5:2]] <= memWdata;
        writeCount <= writeCount + 1;
      end
    end
  end

  always @(negedge clk) ackEn <= stallMode ? ~ackEn : 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refCombine(input logic [4:0] f5, input logic [31:0] o, input logic [31:0] b);
    case (f5)
      5'h00: return o + b;
      5'h04: return o ^ b;
      5'h08: return o | b;
      5'h0C: return o & b;
      5'h10: return ($signed(o) < $signed(b)) ? o : b;
      5'h14: return ($signed(o) > $signed(b)) ? o : b;
      5'h18: return (o < b) ? o : b;
      5'h1C: return (o > b) ? o : b;
      default: return b;
    endcase
  endfunction

  // kind: 0 ignored, 1 illegal, 2 misaligned, 3 executed
  task automatic runOp(input logic [6:0] opc, input logic [2:0] f3, input logic [6:0] f7,
                       input logic [4:0] rd, input logic [31:0] a, input logic [31:0] b,
                       input string tag);
    logic [4:0]  f5;
    bit          legal, sawIll, sawMis, sawWb;
    int          kind, expAcc, expWr, acc0, wr0, idx;
    logic [31:0] expWb, got;
    f5 = f7[6:2];
    legal = f5 inside {5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h18, 5'h1C};
    if (opc != 7'h2F) kind = 0;
    else if (f3 != 3'h2 || !legal) kind = 1;
    else if (a[1:0] != 2'b00) kind = 2;
    else kind = 3;
    idx = int'(a[5:2]);
    expAcc = 0; expWr = 0; expWb = '0;
    if (kind == 3) begin
      if (f5 == 5'h02) begin
        expWb = refMem[idx]; expAcc = 1; resV = 1'b1; resA = a[31:2];
      end else if (f5 == 5'h03) begin
        if (resV && resA == a[31:2]) begin
          refMem[idx] = b; expWb = 32'd0; expAcc = 1; expWr = 1;
        end else expWb = 32'd1;
        resV = 1'b0;
      end else begin
        expWb = refMem[idx]; refMem[idx] = refCombine(f5, refMem[idx], b);
        expAcc = 2; expWr = 1;
      end
    end
    @(negedge clk);
    acc0 = accessCount; wr0 = writeCount;
    reqOpcode = opc; reqFunct3 = f3; reqFunct7 = f7; reqRd = rd;
    rs1Val = a; rs2Val = b; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    sawIll = illegalInstr; sawMis = misalignedFault; sawWb = 1'b0; got = '0;
    for (int i = 0; i < 40; i++) begin
      if (wbValid) begin sawWb = 1'b1; got = wbData; end
      if (!busy) break;
      @(negedge clk);
    end
    if (kind != 3) repeat (3) @(negedge clk);
    chk(sawIll == (kind == 1), {tag, " illegal pulse"}, 32'(sawIll), 32'(kind == 1));
    chk(sawMis == (kind == 2), {tag, " misaligned pulse"}, 32'(sawMis), 32'(kind == 2));
    chk(sawWb == (kind == 3 && rd != 0), {tag, " wb strobe"}, 32'(sawWb), 32'(kind == 3 && rd != 0));
    if (sawWb) chk(got == expWb, {tag, " wb data"}, got, expWb);
    chk(accessCount - acc0 == expAcc, {tag, " access count"}, 32'(accessCount - acc0), 32'(expAcc));
    chk(writeCount - wr0 == expWr, {tag, " write count"}, 32'(writeCount - wr0), 32'(expWr));
    chk(mem[idx] == refMem[idx], {tag, " memory word"}, mem[idx], refMem[idx]);
  endtask

  function automatic logic [6:0] fn(input logic [4:0] f5);
    return {f5, 2'b00};
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0101;
      refMem[i] = mem[i];
    end
    mem[4] = 32'hFFFF_FFF0; refMem[4] = 32'hFFFF_FFF0;
    repeat (3) @(negedge clk);
    chk(!busy && !memReq && !wbValid && !illegalInstr && !misalignedFault,
        "R11 reset idle", {27'd0, busy, memReq, wbValid, illegalInstr, misalignedFault}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    runOp(7'h2F, 3'h2, fn(5'h00), 5'd5, 32'h04, 32'h10, "R5 add");
    runOp(7'h2F, 3'h2, fn(5'h01), 5'd6, 32'h08, 32'hDEAD_BEEF, "R5 swap");
    runOp(7'h2F, 3'h2, fn(5'h04), 5'd7, 32'h0C, 32'h0F0F_00FF, "R5 xor");
    runOp(7'h2F, 3'h2, fn(5'h08), 5'd7, 32'h0C, 32'hA000_0001, "R5 or");
    runOp(7'h2F, 3'h2, fn(5'h0C), 5'd7, 32'h0C, 32'hF0F0_F0F0, "R5 and");
    runOp(7'h2F, 3'h2, fn(5'h10), 5'd8, 32'h10, 32'd5, "R6 signed min");
    runOp(7'h2F, 3'h2, fn(5'h18), 5'd8, 32'h10, 32'd5, "R6 unsigned min");
    runOp(7'h2F, 3'h2, fn(5'h14), 5'd8, 32'h14, 32'h8000_0000, "R6 signed max");
    runOp(7'h2F, 3'h2, fn(5'h1C), 5'd8, 32'h14, 32'h8000_0000, "R6 unsigned max");
    runOp(7'h2F, 3'h2, {5'h00, 2'b11}, 5'd9, 32'h18, 32'd3, "R4 ordering bits add");
    runOp(7'h2F, 3'h2, {5'h01, 2'b10}, 5'd9, 32'h18, 32'h55, "R4 ordering bits swap");
    runOp(7'h2F, 3'h2, fn(5'h02), 5'd10, 32'h20, 32'h0, "R7 load-reserved");
    runOp(7'h2F, 3'h2, fn(5'h03), 5'd11, 32'h20, 32'h1234_5678, "R8 sc pass");
    runOp(7'h2F, 3'h2, fn(5'h03), 5'd11, 32'h20, 32'h9999_9999, "R8 sc after clear");
    runOp(7'h2F, 3'h2, fn(5'h02), 5'd10, 32'h20, 32'h0, "R7 load-reserved again");
    runOp(7'h2F, 3'h2, fn(5'h03), 5'd11, 32'h24, 32'h7777_7777, "R8 sc other word");
    runOp(7'h2F, 3'h2, fn(5'h02), 5'd10, 32'h20, 32'h0, "R7 reserve low");
    runOp(7'h2F, 3'h2, fn(5'h03), 5'd11, 32'h1000_0020, 32'h6666_6666, "R8 sc high bits differ");
    runOp(7'h2F, 3'h3, fn(5'h00), 5'd12, 32'h04, 32'h1, "R2 bad funct3");
    runOp(7'h2F, 3'h2, fn(5'h05), 5'd12, 32'h04, 32'h1, "R3 bad funct5");
    runOp(7'h2F, 3'h2, fn(5'h1F), 5'd12, 32'h04, 32'h1, "R3 bad funct5 high");
    runOp(7'h2F, 3'h2, fn(5'h02), 5'd10, 32'h28, 32'h0, "R9 reserve before fault");
    runOp(7'h2F, 3'h2, fn(5'h00), 5'd12, 32'h2A, 32'h1, "R9 misaligned add");
    runOp(7'h2F, 3'h2, fn(5'h03), 5'd12, 32'h29, 32'h1, "R9 misaligned sc");
    runOp(7'h2F, 3'h2, fn(5'h03), 5'd13, 32'h28, 32'hCAFE_F00D, "R9 reservation kept");
    runOp(7'h33, 3'h2, fn(5'h00), 5'd12, 32'h04, 32'h1, "R1 other opcode");
    runOp(7'h2E, 3'h2, fn(5'h01), 5'd12, 32'h08, 32'h1, "R1 near opcode");
    runOp(7'h2F, 3'h2, fn(5'h00), 5'd0, 32'h30, 32'h40, "R10 rd x0 add");
    runOp(7'h2F, 3'h2, fn(5'h02), 5'd0, 32'h34, 32'h0, "R10 rd x0 lr");

    stallMode = 1'b1;
    runOp(7'h2F, 3'h2, fn(5'h00), 5'd14, 32'h38, 32'h1111, "R11 stalled add");
    runOp(7'h2F, 3'h2, fn(5'h1C), 5'd14, 32'h3C, 32'hFFFF_0000, "R11 stalled maxu");
    runOp(7'h2F, 3'h2, fn(5'h02), 5'd15, 32'h3C, 32'h0, "R11 stalled lr");
    runOp(7'h2F, 3'h2, fn(5'h03), 5'd15, 32'h3C, 32'hBEEF_0001, "R11 stalled sc");
    stallMode = 1'b0;
    repeat (2) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", checks);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule